// File: doc/BRIEF.md
# In-Order Commit Buffer with Precise Faults

This block lets a pipeline finish instructions in any order while still changing architectural registers one at a time in program order. An instruction claims a slot when it is issued and gets back a tag. It hands that tag to whatever unit executes it. When the unit finishes, it writes the result and a fault flag into the slot named by the tag. Slots are freed only from the oldest end. A slot leaves only when its result is present, and it then drives a write to the architectural register it names. The register file belongs to the surrounding design.

A fault is stored with its slot and has no effect until that slot becomes the oldest. By then every older instruction has written its register. Instead of a register write, the block pulses an exception indication carrying the faulting tag. In the same clock it discards every slot, so no younger result can ever reach the register file. The commit step is a separate stage at the end of the pipeline. The buffer holds 16 slots by default, and the depth must be a power of two.

Top module: `rob_core`

## Requirements
- R1: While `rst_n` is low at a rising edge the buffer empties. Afterwards `alloc_ready` is 1, `retire_valid` and `exception_valid` are 0, and `alloc_tag` is 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` high at an edge) takes the slot shown on `alloc_tag`. The tag is the 4-bit slot index, and it advances by one modulo 16 after every accepted allocation, so tags follow program order.
- R3: With 16 live slots `alloc_ready` is 0, and `alloc_valid` then has no effect on the tag sequence or on the buffer contents.
- R4: Completions may arrive for live slots in any order. Each one stores its value and fault flag into the slot selected by `cmpl_tag`.
- R5: `retire_valid` is 1 exactly when the oldest slot is live, completed and not faulted. `retire_dest` and `retire_value` then show that slot, and the oldest position moves by one at the edge.
- R6: The register file written only from the commit port always equals an in-order reference that applies results in allocation order. No result still held in the buffer is ever visible in it.
- R7: A completion to a slot that has already completed, or to a tag with no live slot, changes nothing. The value that later commits is the first one written.
- R8: When the oldest slot is completed with its fault set, `exception_valid` is 1 for exactly that cycle and `exception_tag` shows the slot index. That slot drives no register write.
- R9: At the edge that ends a fault cycle every slot is discarded. The buffer is empty in the next cycle, no younger instruction ever commits, and the next allocation receives the faulting tag.
- R10: During a fault cycle `alloc_ready` is 0, and both allocation and completion inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Request for a new slot |
| alloc_dest | input | 5 | Architectural destination of the new instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | 4 | Tag of the slot the next allocation takes |
| cmpl_valid | input | 1 | A result is being delivered |
| cmpl_tag | input | 4 | Slot the result belongs to |
| cmpl_value | input | 32 | Result data |
| cmpl_fault | input | 1 | The instruction faulted |
| retire_valid | output | 1 | Write `retire_value` to `retire_dest` at this edge |
| retire_dest | output | 5 | Destination register of the oldest slot |
| retire_value | output | 32 | Result of the oldest slot |
| exception_valid | output | 1 | The oldest slot faulted; buffer flushes at this edge |
| exception_tag | output | 4 | Tag of the faulting slot |

## Verification
The bench goes after the following corner cases.
- It fills the buffer to all 16 slots while still asserting allocation. A design with a wrong full test would overwrite the oldest slot, and the tag sequence would break.
- It completes slots youngest first. A design that committed any completed slot would write registers out of order.
- It repeats completions and aims them at slots that are not live. A design that accepted them would commit the wrong value.
- It places faults at random depths, including directly at the oldest slot. A design that flushed late would let younger results reach the register file. A design that took inputs during the flush cycle would leave a stray slot behind, and the tag after the flush would no longer equal the faulting tag.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the per-slot status type of the commit buffer.
// Assumes depth is a power of two so the tag is a plain slot index.
package rob_pkg;
    localparam int ROB_DEPTH  = 16;
    localparam int ROB_DEST_W = 5;
    localparam int ROB_DATA_W = 32;

    // Status bits held for every slot.
    typedef struct packed {
        logic valid;  // slot is occupied by an uncommitted instruction
        logic done;   // result has been delivered
        logic fault;  // delivered result carries a fault
    } rob_flags_t;
endpackage

// File: rtl/rob_ptr.sv
`timescale 1ns/1ps
// Module: rob_ptr
// Circular pointer with one extra wrap bit above the index, so that equal
// pointers mean empty and equal indices with different wrap bits mean full.
// Assumes load and advance are never needed in the same cycle; load wins.
module rob_ptr #(
    parameter int IDX_W = 4,
    localparam int PW   = IDX_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic [PW-1:0] ptr
);
    // Purpose: step, reload or clear the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (adv) begin
            ptr <= ptr + PW'(1);
        end
    end
endmodule

// File: rtl/rob_store.sv
`timescale 1ns/1ps
// Module: rob_store
// Slot storage: status, destination and result of every slot, with one
// allocation write, one completion write and one commit clear per clock,
// and a flush that drops every slot. The oldest slot is read out.
// Assumes the controller never allocates into a live slot; a completion
// counts only for a live slot that has not completed yet.
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH  = ROB_DEPTH,
    parameter int DEST_W = ROB_DEST_W,
    parameter int DATA_W = ROB_DATA_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_we,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [DEST_W-1:0] alloc_dest,
    input  logic              cmpl_we,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic [DATA_W-1:0] cmpl_value,
    input  logic              cmpl_fault,
    input  logic              retire_we,
    input  logic [IDX_W-1:0]  head_idx,
    output rob_flags_t        head_flags,
    output logic [DEST_W-1:0] head_dest,
    output logic [DATA_W-1:0] head_value
);
    rob_flags_t        flg_arr [DEPTH];
    logic [DEST_W-1:0] dst_arr [DEPTH];
    logic [DATA_W-1:0] val_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rob_flags_t        flg_q;
        logic [DEST_W-1:0] dst_q;
        logic [DATA_W-1:0] val_q;
        logic              hit_a;
        logic              hit_c;
        logic              hit_r;

        assign hit_a = alloc_we  && (alloc_idx == IDX_W'(g));
        assign hit_c = cmpl_we   && (cmpl_idx  == IDX_W'(g)) && flg_q.valid && !flg_q.done;
        assign hit_r = retire_we && (head_idx  == IDX_W'(g));

        // Purpose: track occupancy, completion and fault of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                flg_q <= '0;
            end else if (hit_a) begin
                flg_q <= '{valid: 1'b1, done: 1'b0, fault: 1'b0};
            end else if (hit_c) begin
                flg_q.done  <= 1'b1;
                flg_q.fault <= cmpl_fault;
            end else if (hit_r) begin
                flg_q.valid <= 1'b0;
            end
        end

        // Purpose: capture destination on allocation and result on completion.
        always_ff @(posedge clk) begin
            if (hit_a) dst_q <= alloc_dest;
            if (hit_c) val_q <= cmpl_value;
        end

        assign flg_arr[g] = flg_q;
        assign dst_arr[g] = dst_q;
        assign val_arr[g] = val_q;
    end

    // Purpose: read out the oldest slot.
    always_comb begin
        head_flags = flg_arr[head_idx];
        head_dest  = dst_arr[head_idx];
        head_value = val_arr[head_idx];
    end
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
// Module: rob_core (top)
// In-order commit buffer. Slots are claimed at the tail in program order,
// filled in any order by tag, and leave from the head only when completed.
// A faulted head raises a one-cycle exception and flushes every slot.
// Assumes DEPTH is a power of two and callers complete only tags they hold.
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = ROB_DEPTH,
    parameter int DEST_W = ROB_DEST_W,
    parameter int DATA_W = ROB_DATA_W,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [DEST_W-1:0] alloc_dest,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_tag,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_tag,
    input  logic [DATA_W-1:0] cmpl_value,
    input  logic              cmpl_fault,
    output logic              retire_valid,
    output logic [DEST_W-1:0] retire_dest,
    output logic [DATA_W-1:0] retire_value,
    output logic              exception_valid,
    output logic [IDX_W-1:0]  exception_tag
);
    logic [PW-1:0] head_ptr;
    logic [PW-1:0] tail_ptr;
    logic [PW-1:0] occupancy;
    logic          full;
    logic          head_ready;
    logic          flush;
    logic          alloc_fire;
    logic          cmpl_we;
    rob_flags_t    head_flags;

    // Purpose: derive fill level and the commit/fault decision for the head.
    always_comb begin
        occupancy       = tail_ptr - head_ptr;
        full            = (occupancy == PW'(DEPTH));
        head_ready      = head_flags.valid && head_flags.done;
        flush           = head_ready && head_flags.fault;
        retire_valid    = head_ready && !head_flags.fault;
        exception_valid = flush;
        exception_tag   = head_ptr[IDX_W-1:0];
        alloc_ready     = !full && !flush;
        alloc_tag       = tail_ptr[IDX_W-1:0];
        alloc_fire      = alloc_valid && alloc_ready;
        cmpl_we         = cmpl_valid && !flush;
    end

    rob_ptr #(.IDX_W(IDX_W)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (retire_valid),
        .load     (1'b0),
        .load_val ('0),
        .ptr      (head_ptr)
    );

    rob_ptr #(.IDX_W(IDX_W)) u_tail (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (alloc_fire),
        .load     (flush),
        .load_val (head_ptr),
        .ptr      (tail_ptr)
    );

    rob_store #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .alloc_we   (alloc_fire),
        .alloc_idx  (tail_ptr[IDX_W-1:0]),
        .alloc_dest (alloc_dest),
        .cmpl_we    (cmpl_we),
        .cmpl_idx   (cmpl_tag),
        .cmpl_value (cmpl_value),
        .cmpl_fault (cmpl_fault),
        .retire_we  (retire_valid),
        .head_idx   (head_ptr[IDX_W-1:0]),
        .head_flags (head_flags),
        .head_dest  (retire_dest),
        .head_value (retire_value)
    );
endmodule

// File: rtl/rob_core_chk.sv
`timescale 1ns/1ps
// Module: rob_core_chk
// Property checker for rob_core, bound to every instance. It watches the
// ports together with the head and tail pointers the two pointer
// instances produce.
module rob_core_chk #(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PW    = IDX_W + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic          retire_valid,
    input logic          exception_valid,
    input logic [PW-1:0] head_ptr,
    input logic [PW-1:0] tail_ptr
);
    logic [PW-1:0] occ;
    assign occ = tail_ptr - head_ptr;

    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == PW'(DEPTH)) |-> !alloc_ready);

    p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> (tail_ptr == $past(tail_ptr) + PW'(1)));

    p_head_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> (head_ptr == $past(head_ptr) + PW'(1)));

    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(retire_valid && exception_valid));

    p_exc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exception_valid |=> !exception_valid);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exception_valid |=> (head_ptr == tail_ptr) && !retire_valid);

    p_flush_no_alloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exception_valid |-> !alloc_ready);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .alloc_valid     (alloc_valid),
    .alloc_ready     (alloc_ready),
    .retire_valid    (retire_valid),
    .exception_valid (exception_valid),
    .head_ptr        (head_ptr),
    .tail_ptr        (tail_ptr)
);

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
// Bench for rob_core: directed fill/drain/fault phases plus seeded random
// traffic, checked every cycle against an in-order queue model.
module rob_core_tb;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid;
    logic [4:0]  alloc_dest;
    logic        alloc_ready;
    logic [3:0]  alloc_tag;
    logic        cmpl_valid;
    logic [3:0]  cmpl_tag;
    logic [31:0] cmpl_value;
    logic        cmpl_fault;
    logic        retire_valid;
    logic [4:0]  retire_dest;
    logic [31:0] retire_value;
    logic        exception_valid;
    logic [3:0]  exception_tag;

    always #10 clk = ~clk;

    rob_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .cmpl_value(cmpl_value), .cmpl_fault(cmpl_fault),
        .retire_valid(retire_valid), .retire_dest(retire_dest),
        .retire_value(retire_value),
        .exception_valid(exception_valid), .exception_tag(exception_tag)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n_exc   = 0;
    bit finished = 1'b0;

    // Architectural file written only from the commit port, and its reference.
    logic [31:0] arf     [32];
    logic [31:0] ref_arf [32];

    // In-order model of live slots, oldest at index 0.
    logic [3:0]  q_tag [D];
    logic [4:0]  q_dst [D];
    logic [31:0] q_val [D];
    logic        q_done[D];
    logic        q_flt [D];
    int          qn;
    logic [3:0]  tail_m;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit arf_match();
        for (int i = 0; i < 32; i++)
            if (arf[i] !== ref_arf[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int count_mismatch();
        int c = 0;
        for (int i = 0; i < 32; i++)
            if (arf[i] !== ref_arf[i]) c++;
        return c;
    endfunction

    task automatic pop();
        for (int i = 0; i < D - 1; i++) begin
            q_tag[i] = q_tag[i+1]; q_dst[i] = q_dst[i+1]; q_val[i] = q_val[i+1];
            q_done[i] = q_done[i+1]; q_flt[i] = q_flt[i+1];
        end
        qn--;
    endtask

    // One cycle: check outputs, update model, drive inputs for the next edge.
    // cm: 0 no completion, 1 random live slot, 2 youngest first.
    task automatic step(input int ap, input int cm, input int fp, input int dp);
        bit er, ee, ar;
        int pick, nd, k;
        er = (qn > 0) && q_done[0] && !q_flt[0];
        ee = (qn > 0) && q_done[0] &&  q_flt[0];
        ar = (qn < D) && !ee;
        chk(retire_valid == er, "R5", "retire_valid", 32'(retire_valid), 32'(er));
        chk(exception_valid == ee, "R8", "exception_valid", 32'(exception_valid), 32'(ee));
        chk(alloc_ready == ar, ee ? "R10" : "R3", "alloc_ready", 32'(alloc_ready), 32'(ar));
        if (retire_valid) arf[retire_dest] = retire_value;
        if (er) begin
            chk(retire_dest == q_dst[0], "R6", "retire_dest", 32'(retire_dest), 32'(q_dst[0]));
            chk(retire_value == q_val[0], "R7", "retire_value", retire_value, q_val[0]);
            ref_arf[q_dst[0]] = q_val[0];
            pop();
        end
        if (ee) begin
            chk(exception_tag == q_tag[0], "R8", "exception_tag", 32'(exception_tag), 32'(q_tag[0]));
            chk(arf_match(), "R6", "register mismatches at fault", 32'(count_mismatch()), 32'd0);
            tail_m = q_tag[0];
            qn = 0;
            n_exc++;
        end
        // completion
        cmpl_valid = 1'b0;
        cmpl_tag   = 4'($urandom);
        cmpl_value = $urandom;
        cmpl_fault = 1'b0;
        if (ee) begin
            cmpl_valid = 1'($urandom);          // R10: must be ignored
            cmpl_fault = 1'($urandom);
        end else if (($urandom % 100) < dp && qn > 0) begin
            pick = -1;
            for (int i = 0; i < qn; i++) if (q_done[i]) pick = i;
            cmpl_valid = 1'b1;                  // R7: stale or non-live tag
            cmpl_tag   = (pick >= 0) ? q_tag[pick] : tail_m;
            cmpl_fault = 1'($urandom);
            if (pick < 0 && qn == D) cmpl_valid = 1'b0;
        end else if (cm != 0) begin
            nd = 0;
            for (int i = 0; i < qn; i++) if (!q_done[i]) nd++;
            pick = -1;
            if (nd > 0) begin
                k = (cm == 2) ? nd - 1 : int'($urandom % nd);
                for (int i = 0; i < qn; i++)
                    if (!q_done[i]) begin
                        if (k == 0) pick = i;
                        k--;
                    end
            end
            if (pick >= 0) begin
                cmpl_valid   = 1'b1;
                cmpl_tag     = q_tag[pick];
                cmpl_fault   = (($urandom % 100) < fp);
                q_done[pick] = 1'b1;
                q_val[pick]  = cmpl_value;
                q_flt[pick]  = cmpl_fault;
            end
        end
        // allocation
        alloc_valid = (($urandom % 100) < ap);
        alloc_dest  = 5'($urandom);
        if (alloc_valid && ar) begin
            chk(alloc_tag == tail_m, "R2", "alloc_tag", 32'(alloc_tag), 32'(tail_m));
            q_tag[qn] = tail_m; q_dst[qn] = alloc_dest; q_val[qn] = '0;
            q_done[qn] = 1'b0; q_flt[qn] = 1'b0;
            qn++;
            tail_m = tail_m + 4'd1;
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) begin arf[i] = '0; ref_arf[i] = '0; end
        qn = 0; tail_m = '0;
        rst_n = 1'b0; alloc_valid = 1'b0; alloc_dest = '0;
        cmpl_valid = 1'b0; cmpl_tag = '0; cmpl_value = '0; cmpl_fault = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        chk(alloc_ready == 1'b1, "R1", "alloc_ready", 32'(alloc_ready), 32'd1);
        chk(retire_valid == 1'b0, "R1", "retire_valid", 32'(retire_valid), 32'd0);
        chk(exception_valid == 1'b0, "R1", "exception_valid", 32'(exception_valid), 32'd0);
        chk(alloc_tag == 4'd0, "R1", "alloc_tag", 32'(alloc_tag), 32'd0);
        // R3: fill past full with no completions
        repeat (22) step(100, 0, 0, 0);
        chk(qn == D, "R3", "model fill level", 32'(qn), 32'(D));
        // R4/R5: complete youngest first, in-order drain
        repeat (40) step(0, 2, 0, 0);
        chk(qn == 0, "R5", "drain left slots", 32'(qn), 32'd0);
        // R8/R9: faults near and at the head
        repeat (30) step(100, 1, 100, 0);
        repeat (30) step(0, 1, 0, 0);
        // mixed random traffic with faults and stale completions (R4, R7, R9)
        repeat (4000) step(60, 1, 4, 10);
        repeat (60) step(0, 1, 0, 0);
        chk(n_exc > 0, "R9", "fault events seen", 32'(n_exc), 32'd1);
        chk(arf_match(), "R6", "final register mismatches", 32'(count_mismatch()), 32'd0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule